// File: doc/BRIEF.md
# Stored-Program Sequencer

This block is the automatic control unit that sits in front of a small register-and-ALU datapath. After a run pulse it clears its program counter and repeats a fixed loop. It reads the word at the program counter from the shared instruction/data memory and latches it into its instruction register. It then advances the counter and turns the bit fields of the word straight into datapath settings: operand and destination register selects, ALU function, bus switches, memory address and memory read/write enables. Finally it launches exactly one datapath cycle and waits for that cycle to report completion.

There is no microcode. Each field of the 16-bit word is wired onto one group of control outputs. The opcode only picks which switches close. A halt word, or any opcode outside the defined set, ends the run without a datapath cycle. The block then reports halted until the next run pulse.

Memory fetches use a request channel and a response channel, each with valid/ready. The memory may stall the request, and it may return the word any number of cycles later. The datapath is controlled through a one-cycle start pulse and a done input.

Top module: `spc_top`

## Requirements
- R1: While reset is applied and in the first cycle after it: busy, halted, mem_req_valid and dp_start are low and pc_o is 0.
- R2: A run pulse seen while the block is idle or halted clears the program counter. In the next cycle mem_req_valid is high with mem_req_addr 0.
- R3: Request back-pressure: once mem_req_valid is high, it stays high and mem_req_addr stays unchanged until a cycle in which mem_req_ready is high. mem_rsp_ready is high only while a fetch response is awaited. The word is taken in the first cycle where both mem_rsp_valid and mem_rsp_ready are high.
- R4: Each accepted response word goes into the instruction register and the program counter advances by one. Successive fetch requests therefore use addresses 0, 1, 2, ... in order, and pc_o shows the advanced value.
- R5: Word layout: opcode in bits [15:13], destination select in [12:11], A-operand select in [10:9], B-operand select in [8:7], memory address in [6:0]. The three selects and the address are copied onto dp_sel_c, dp_sel_a, dp_sel_b and dp_addr for every executed opcode.
- R6: Opcode 1 (add) and opcode 2 (subtract) set dp_reg_we=1 and dp_reg_from_mem=0, with dp_mem_re=0 and dp_mem_we=0. dp_alu_op is 0 for add and 1 for subtract.
- R7: Opcode 3 (load) sets dp_mem_re, dp_reg_we and dp_reg_from_mem. Opcode 4 (store) sets dp_mem_we with dp_mem_from_alu=0, so the A operand is written to memory. Opcode 5 (add-to-memory) sets dp_mem_we and dp_mem_from_alu with dp_alu_op=0. All other control flags are 0.
- R8: For each executed instruction, dp_start is high for exactly one cycle, two cycles after the response handshake. The control outputs are valid from that cycle and stay unchanged until dp_done is taken.
- R9: No new fetch is requested between dp_start and the dp_done that ends the cycle. dp_done seen in any other state has no effect.
- R10: Opcode 0 (halt) and the undefined opcodes 6 and 7 still advance the program counter but produce no dp_start. halted rises two cycles after their response handshake.
- R11: halted stays high, and no request or dp_start is issued, until a run pulse. A run pulse while busy is ignored.
- R12: The program "load R0 from 5, load R1 from 6, R2=R0+R1, store R2 to 7, halt" placed at addresses 0..4 leaves the sum of words 5 and 6 in word 7 and stops with pc_o = 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start pulse; restarts from address 0 when idle or halted |
| busy | output | 1 | Execution in progress |
| halted | output | 1 | Stopped on a halt or undefined opcode |
| pc_o | output | 7 | Current program counter |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the fetch request |
| mem_req_addr | output | 7 | Fetch address |
| mem_rsp_valid | input | 1 | Fetched word valid |
| mem_rsp_ready | output | 1 | Block accepts the fetched word |
| mem_rsp_data | input | 16 | Fetched instruction word |
| dp_start | output | 1 | One-cycle datapath cycle launch |
| dp_done | input | 1 | Datapath cycle finished |
| dp_alu_op | output | 1 | ALU function: 0 add, 1 subtract |
| dp_sel_a | output | 2 | A-operand register select |
| dp_sel_b | output | 2 | B-operand register select |
| dp_sel_c | output | 2 | Destination register select |
| dp_reg_we | output | 1 | Write destination register |
| dp_reg_from_mem | output | 1 | Destination takes memory data instead of ALU result |
| dp_mem_re | output | 1 | Read memory at dp_addr |
| dp_mem_we | output | 1 | Write memory at dp_addr |
| dp_mem_from_alu | output | 1 | Memory write data is ALU result instead of A operand |
| dp_addr | output | 7 | Data memory address |

## Verification
The fixed reference program gives a known end result and shows the basic load/add/store/halt path. Random programs mixing all five working opcodes run under random request stalls, random response latency and random datapath completion delay. They are compared against an independent instruction-level model, which separates fetch ordering and field mapping errors from handshake timing errors. Directed programs cover a halt as the first word, an undefined opcode mid-program, a restart from halted, a run pulse while busy, and done pulses outside a datapath cycle. Each of these shows a stop or ignore rule that the random mixes seldom reach.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 3;
  localparam int unsigned RSEL_W = 2;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned OP_LSB = WORD_W - OP_W;
  localparam int unsigned C_LSB  = OP_LSB - RSEL_W;
  localparam int unsigned A_LSB  = C_LSB - RSEL_W;
  localparam int unsigned B_LSB  = A_LSB - RSEL_W;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4,
    OP_ADDM  = 3'd5
  } opcode_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_SUB = 1'b1
  } alu_e;

  typedef struct packed {
    alu_e              alu_op;
    logic [RSEL_W-1:0] sel_a;
    logic [RSEL_W-1:0] sel_b;
    logic [RSEL_W-1:0] sel_c;
    logic              reg_we;
    logic              reg_from_mem;
    logic              mem_re;
    logic              mem_we;
    logic              mem_from_alu;
    logic [ADDR_W-1:0] addr;
  } dp_ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_DECODE, S_EXEC, S_HALTED
  } seq_state_e;
endpackage

// File: rtl/spc_fetch.sv
module spc_fetch
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_clear,
  input  logic              ir_load,
  input  logic [WORD_W-1:0] ir_in,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] ir
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
    end else if (pc_clear) begin
      pc <= '0;
    end else if (ir_load) begin
      ir <= ir_in;
      pc <= pc + 1'b1;
    end
  end

  // R4: a captured word never leaves the counter where it was
  assert_ir_moves_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_load && !pc_clear) |=> (pc != $past(pc)));
endmodule

// File: rtl/spc_decode.sv
module spc_decode
  import spc_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output dp_ctl_t           ctl,
  output logic              is_stop
);
  logic [OP_W-1:0] op;

  always_comb begin
    op               = ir[WORD_W-1:OP_LSB];
    ctl              = '0;
    ctl.sel_c        = ir[C_LSB +: RSEL_W];
    ctl.sel_a        = ir[A_LSB +: RSEL_W];
    ctl.sel_b        = ir[B_LSB +: RSEL_W];
    ctl.addr         = ir[ADDR_W-1:0];
    ctl.alu_op       = ALU_ADD;
    is_stop          = 1'b0;
    case (op)
      OP_ADD:   ctl.reg_we = 1'b1;
      OP_SUB: begin
        ctl.reg_we = 1'b1;
        ctl.alu_op = ALU_SUB;
      end
      OP_LOAD: begin
        ctl.mem_re       = 1'b1;
        ctl.reg_we       = 1'b1;
        ctl.reg_from_mem = 1'b1;
      end
      OP_STORE: ctl.mem_we = 1'b1;
      OP_ADDM: begin
        ctl.mem_we       = 1'b1;
        ctl.mem_from_alu = 1'b1;
      end
      default:  is_stop = 1'b1;
    endcase
  end
endmodule

// File: rtl/spc_seq.sv
module spc_seq
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic dp_done,
  input  logic is_stop,
  output logic req_valid,
  output logic rsp_ready,
  output logic pc_clear,
  output logic ir_load,
  output logic ctl_load,
  output logic in_exec,
  output logic dp_start,
  output logic busy,
  output logic halted
);
  seq_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE, S_HALTED: if (run) state_nx = S_FETCH;
      S_FETCH:          if (req_ready) state_nx = S_FWAIT;
      S_FWAIT:          if (rsp_valid) state_nx = S_DECODE;
      S_DECODE:         state_nx = is_stop ? S_HALTED : S_EXEC;
      S_EXEC:           if (dp_done) state_nx = S_FETCH;
      default:          state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dp_start <= 1'b0;
    end else begin
      state    <= state_nx;
      dp_start <= (state == S_DECODE) && !is_stop;
    end
  end

  assign req_valid = (state == S_FETCH);
  assign rsp_ready = (state == S_FWAIT);
  assign pc_clear  = ((state == S_IDLE) || (state == S_HALTED)) && run;
  assign ir_load   = (state == S_FWAIT) && rsp_valid;
  assign ctl_load  = (state == S_DECODE) && !is_stop;
  assign in_exec   = (state == S_EXEC);
  assign busy      = (state != S_IDLE) && (state != S_HALTED);
  assign halted    = (state == S_HALTED);

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> !dp_start);
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!req_valid && !dp_start && !rsp_ready));
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);
  assert_no_fetch_in_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !dp_done) |=> !req_valid);
endmodule

// File: rtl/spc_ctlreg.sv
module spc_ctlreg
  import spc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  dp_ctl_t d,
  output dp_ctl_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/spc_top.sv
module spc_top
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              busy,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              dp_start,
  input  logic              dp_done,
  output logic              dp_alu_op,
  output logic [RSEL_W-1:0] dp_sel_a,
  output logic [RSEL_W-1:0] dp_sel_b,
  output logic [RSEL_W-1:0] dp_sel_c,
  output logic              dp_reg_we,
  output logic              dp_reg_from_mem,
  output logic              dp_mem_re,
  output logic              dp_mem_we,
  output logic              dp_mem_from_alu,
  output logic [ADDR_W-1:0] dp_addr
);
  logic              pc_clear, ir_load, ctl_load, in_exec, is_stop;
  logic [WORD_W-1:0] ir;
  logic [ADDR_W-1:0] pc;
  dp_ctl_t           ctl_d, ctl_q;

  spc_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .pc_clear(pc_clear), .ir_load(ir_load),
    .ir_in(mem_rsp_data), .pc(pc), .ir(ir)
  );

  spc_decode u_decode (.ir(ir), .ctl(ctl_d), .is_stop(is_stop));

  spc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .req_ready(mem_req_ready),
    .rsp_valid(mem_rsp_valid), .dp_done(dp_done), .is_stop(is_stop),
    .req_valid(mem_req_valid), .rsp_ready(mem_rsp_ready), .pc_clear(pc_clear),
    .ir_load(ir_load), .ctl_load(ctl_load), .in_exec(in_exec),
    .dp_start(dp_start), .busy(busy), .halted(halted)
  );

  spc_ctlreg u_ctl (.clk(clk), .rst_n(rst_n), .load(ctl_load), .d(ctl_d), .q(ctl_q));

  assign pc_o            = pc;
  assign mem_req_addr    = pc;
  assign dp_alu_op       = ctl_q.alu_op;
  assign dp_sel_a        = ctl_q.sel_a;
  assign dp_sel_b        = ctl_q.sel_b;
  assign dp_sel_c        = ctl_q.sel_c;
  assign dp_reg_we       = ctl_q.reg_we;
  assign dp_reg_from_mem = ctl_q.reg_from_mem;
  assign dp_mem_re       = ctl_q.mem_re;
  assign dp_mem_we       = ctl_q.mem_we;
  assign dp_mem_from_alu = ctl_q.mem_from_alu;
  assign dp_addr         = ctl_q.addr;

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (pc_o == $past(pc_o) + 1'b1));
  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !dp_start) |-> $stable(ctl_q));
  assert_run_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !busy) |=> (mem_req_valid && pc_o == '0));
endmodule

// File: tb/spc_top_tb_top.sv
`timescale 1ns/1ps
module spc_top_tb_top;
  import spc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, run, mem_req_ready, mem_rsp_valid, dp_done;
  logic [15:0] mem_rsp_data;
  logic        busy, halted, mem_req_valid, mem_rsp_ready, dp_start;
  logic [6:0]  pc_o, mem_req_addr, dp_addr;
  logic        dp_alu_op, dp_reg_we, dp_reg_from_mem, dp_mem_re, dp_mem_we, dp_mem_from_alu;
  logic [1:0]  dp_sel_a, dp_sel_b, dp_sel_c;

  always #10 clk = ~clk;

  spc_top dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .busy(busy), .halted(halted), .pc_o(pc_o),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .dp_start(dp_start), .dp_done(dp_done), .dp_alu_op(dp_alu_op),
    .dp_sel_a(dp_sel_a), .dp_sel_b(dp_sel_b), .dp_sel_c(dp_sel_c),
    .dp_reg_we(dp_reg_we), .dp_reg_from_mem(dp_reg_from_mem), .dp_mem_re(dp_mem_re),
    .dp_mem_we(dp_mem_we), .dp_mem_from_alu(dp_mem_from_alu), .dp_addr(dp_addr)
  );

  logic [15:0] mem [128];
  logic [15:0] gold_mem [128];
  logic [15:0] regs [4];
  logic [15:0] gregs [4];
  int          n_chk = 0, n_err = 0, cyc = 0;
  int          gold_pc, gold_starts, n_starts, exp_pc, since_rsp, rsp_delay, done_wait;
  bit          awaiting, exec_busy, run_req, run_prev, req_wait_prev, halted_prev;
  bit          inject_busy_run, busy_run_prev, spurious_done, abort;
  logic [6:0]  rsp_addr, req_addr_prev;
  logic [15:0] last_word;
  dp_ctl_t     snap;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int c, input int a,
                                      input int b, input int addr);
    return {op[2:0], c[1:0], a[1:0], b[1:0], addr[6:0]};
  endfunction

  // expected control settings from the word layout (R5, R6, R7)
  function automatic dp_ctl_t exp_ctl(input logic [15:0] w);
    dp_ctl_t e;
    e = '0;
    e.sel_c = w[12:11];
    e.sel_a = w[10:9];
    e.sel_b = w[8:7];
    e.addr  = w[6:0];
    e.alu_op = (w[15:13] == 3'd2) ? ALU_SUB : ALU_ADD;
    case (w[15:13])
      3'd1, 3'd2: e.reg_we = 1'b1;
      3'd3: begin e.mem_re = 1'b1; e.reg_we = 1'b1; e.reg_from_mem = 1'b1; end
      3'd4: e.mem_we = 1'b1;
      3'd5: begin e.mem_we = 1'b1; e.mem_from_alu = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic dp_ctl_t port_ctl();
    dp_ctl_t c;
    c.alu_op = alu_e'(dp_alu_op);
    c.sel_a = dp_sel_a; c.sel_b = dp_sel_b; c.sel_c = dp_sel_c;
    c.reg_we = dp_reg_we; c.reg_from_mem = dp_reg_from_mem;
    c.mem_re = dp_mem_re; c.mem_we = dp_mem_we; c.mem_from_alu = dp_mem_from_alu;
    c.addr = dp_addr;
    return c;
  endfunction

  // instruction-level reference of a whole program
  task automatic golden();
    int pc = 0;
    gold_starts = 0;
    for (int i = 0; i < 4; i++) gregs[i] = '0;
    for (int s = 0; s < 128; s++) begin
      logic [15:0] w = gold_mem[pc];
      logic [1:0] c = w[12:11], a = w[10:9], b = w[8:7];
      logic [6:0] ad = w[6:0];
      pc = (pc + 1) % 128;
      if (w[15:13] == 3'd0 || w[15:13] > 3'd5) break;
      gold_starts++;
      case (w[15:13])
        3'd1: gregs[c] = gregs[a] + gregs[b];
        3'd2: gregs[c] = gregs[a] - gregs[b];
        3'd3: gregs[c] = gold_mem[ad];
        3'd4: gold_mem[ad] = gregs[a];
        default: gold_mem[ad] = gregs[a] + gregs[b];
      endcase
    end
    gold_pc = pc;
  endtask

  // datapath model: acts on whatever the controls say
  task automatic apply_dp(input dp_ctl_t c);
    logic [15:0] alu;
    alu = (c.alu_op == ALU_SUB) ? regs[c.sel_a] - regs[c.sel_b] : regs[c.sel_a] + regs[c.sel_b];
    if (c.reg_we) regs[c.sel_c] = c.reg_from_mem ? mem[c.addr] : alu;
    if (c.mem_we) mem[c.addr] = c.mem_from_alu ? alu : regs[c.sel_a];
  endtask

  task automatic step();
    dp_ctl_t cur, e;
    @(negedge clk);
    cyc++;
    if (cyc > 190000) abort = 1;
    cur = port_ctl();
    since_rsp++;
    if (run_prev) begin
      chk(mem_req_valid === 1'b1 && mem_req_addr == 7'd0, "R2", "restart fetch", mem_req_addr, 0);
      run_prev = 0;
    end
    if (busy_run_prev) begin
      chk(busy === 1'b1 && pc_o == exp_pc[6:0], "R11", "run while busy", pc_o, exp_pc);
      busy_run_prev = 0;
    end
    if (req_wait_prev)
      chk(mem_req_valid === 1'b1 && mem_req_addr == req_addr_prev, "R3", "request held",
          mem_req_addr, req_addr_prev);
    if (mem_rsp_ready) chk(awaiting, "R3", "rsp_ready without pending fetch", 1, 0);
    if (exec_busy && mem_req_valid) chk(0, "R9", "fetch during datapath cycle", 1, 0);
    if (dp_start) begin
      e = exp_ctl(last_word);
      chk(since_rsp == 2, "R8", "start latency", since_rsp, 2);
      chk(!exec_busy, "R8", "single start", exec_busy, 0);
      chk(cur == e, (last_word[15:13] <= 3'd2) ? "R6" : "R7", "controls", cur, e);
      snap = cur;
      apply_dp(cur);
      exec_busy = 1;
      n_starts++;
      done_wait = $urandom_range(0, 3);
    end else if (exec_busy) begin
      chk(cur == snap, "R8", "controls held", cur, snap);
    end
    if (halted && !halted_prev) chk(since_rsp == 2, "R10", "halt latency", since_rsp, 2);
    halted_prev = halted;

    // drive inputs for the next edge
    run = 1'b0;
    if (run_req) begin
      run = 1'b1; run_req = 0; run_prev = 1; exp_pc = 0;
    end else if (inject_busy_run && exec_busy && !dp_start && exp_pc > 1) begin
      run = 1'b1; inject_busy_run = 0; busy_run_prev = 1;
    end
    dp_done = 1'b0;
    if (exec_busy && !dp_start) begin
      if (done_wait == 0) begin dp_done = 1'b1; exec_busy = 0; end
      else done_wait--;
    end else if (exec_busy && done_wait == 0) begin
      dp_done = 1'b1; exec_busy = 0;
    end else if (exec_busy) begin
      done_wait--;
    end else if (spurious_done) begin
      dp_done = ($urandom_range(0, 2) == 0);  // R9: must be ignored
    end
    mem_req_ready = ($urandom_range(0, 3) != 0);
    if (mem_req_valid && mem_req_ready) begin
      chk(mem_req_addr == exp_pc[6:0], "R4", "fetch address", mem_req_addr, exp_pc);
      awaiting = 1; rsp_addr = mem_req_addr; rsp_delay = $urandom_range(0, 2);
      req_wait_prev = 0;
      mem_rsp_valid = 1'b0;
    end else begin
      req_wait_prev = mem_req_valid;
      req_addr_prev = mem_req_addr;
      mem_rsp_valid = 1'b0;
      if (awaiting) begin
        if (rsp_delay > 0) rsp_delay--;
        else begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[rsp_addr];
          if (mem_rsp_ready) begin
            last_word = mem[rsp_addr]; awaiting = 0; since_rsp = 0;
            exp_pc = (exp_pc + 1) % 128;
          end
        end
      end
    end
  endtask

  task automatic run_prog(input string tag, input bit busy_run);
    int guard = 0;
    for (int i = 0; i < 128; i++) gold_mem[i] = mem[i];
    golden();
    for (int i = 0; i < 4; i++) regs[i] = '0;
    n_starts = 0;
    inject_busy_run = busy_run;
    run_req = 1;
    step();
    step();
    while (!halted && !abort && guard < 4000) begin step(); guard++; end
    if (!halted) chk(0, tag, "watchdog expired", guard, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      chk(halted && !busy && !mem_req_valid && !dp_start, "R11", "halted hold", halted, 1);
    end
    chk(pc_o == gold_pc[6:0], "R10", "final pc", pc_o, gold_pc);
    chk(n_starts == gold_starts, "R10", "datapath cycles", n_starts, gold_starts);
    for (int i = 0; i < 4; i++) chk(regs[i] == gregs[i], tag, "register", regs[i], gregs[i]);
    for (int i = 0; i < 128; i++)
      if (mem[i] != gold_mem[i]) chk(0, tag, "memory word", mem[i], gold_mem[i]);
    chk(1, tag, "memory compare", 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run = 1'b0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; dp_done = 1'b0;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !halted && !mem_req_valid && !dp_start && pc_o == 0, "R1", "in reset", pc_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !halted && !mem_req_valid && !dp_start && pc_o == 0, "R1", "after reset", busy, 0);

    // R12 reference program
    mem[0] = enc(3, 0, 0, 0, 5);
    mem[1] = enc(3, 1, 0, 0, 6);
    mem[2] = enc(1, 2, 0, 1, 0);
    mem[3] = enc(4, 0, 2, 0, 7);
    mem[4] = enc(0, 0, 0, 0, 0);
    mem[5] = 16'h1234; mem[6] = 16'h0FF0;
    run_prog("R12", 0);
    chk(mem[7] == 16'h2224, "R12", "sum stored", mem[7], 16'h2224);
    chk(pc_o == 7'd5, "R12", "stop pc", pc_o, 5);

    // halt as first word, restart from halted
    for (int i = 0; i < 128; i++) mem[i] = '0;
    run_prog("R10", 0);
    chk(n_starts == 0 && pc_o == 7'd1, "R10", "halt first", pc_o, 1);

    // undefined opcode mid-program, with subtract and spurious done
    mem[0] = enc(3, 1, 0, 0, 100);
    mem[1] = enc(2, 3, 1, 1, 0);
    mem[2] = enc(6, 0, 0, 0, 0);
    mem[3] = enc(1, 0, 1, 1, 0);
    mem[100] = 16'h0042;
    spurious_done = 1;
    run_prog("R10", 0);
    chk(n_starts == 2 && pc_o == 7'd3, "R10", "undefined stops", pc_o, 3);
    chk(regs[1] == 16'h0042 && regs[3] == 16'h0000, "R6", "subtract", regs[3], 0);

    // random programs
    for (int p = 0; p < 40 && !abort; p++) begin
      int len = $urandom_range(2, 20);
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 64; i < 128; i++) mem[i] = 16'($urandom);
      for (int i = 0; i < len; i++)
        mem[i] = enc($urandom_range(1, 5), $urandom_range(0, 3), $urandom_range(0, 3),
                     $urandom_range(0, 3), $urandom_range(64, 127));
      case ($urandom_range(0, 2))
        0: mem[len] = enc(0, 0, 0, 0, 0);
        1: mem[len] = enc(6, 1, 2, 3, 9);
        default: mem[len] = enc(7, 3, 3, 3, 127);
      endcase
      spurious_done = (p % 2 == 1);
      run_prog("R7", (p % 3 == 0));
    end

    if (abort) chk(0, "R8", "global watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule